// File: doc/BRIEF.md
# Committed-Store Drain Queue with Load Forwarding

This block holds stores that have already retired, between the commit stage and the data cache. Commit hands over one word-aligned, full-word store (address and data) per cycle. The store counts as architecturally complete on the cycle the queue accepts it. The queue then writes its entries to the cache one at a time, oldest first, over a request/acknowledge handshake. An entry leaves the queue only once the cache has acknowledged its write.

While stores wait in the queue, the cache alone no longer holds the current memory value. Every load therefore also probes this queue, alongside the cache. One cycle later the queue reports whether it holds the address and, if so, the data. When several queued stores share the address, the reported data is the youngest one. A queue hit takes precedence over whatever the cache returns. When every slot is occupied, the queue raises a full indication so that commit can stall.

Top module: `store_wb_buffer`

## Requirements
- R1: A store offered with `st_valid` high while `wb_full` is low is accepted at that clock edge. Accepted stores reach the cache in the order they were accepted.
- R2: `mem_req` is high exactly when at least one entry is held. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R3: `mem_addr`/`mem_data` always present the oldest held entry. That entry is removed only at an edge where `mem_ack` is high, and the next-oldest entry is presented from the following cycle.
- R4: `wb_full` is high exactly when DEPTH entries are held (default 8). It drops only in the cycle after an acknowledge that was not paired with an enqueue.
- R5: A store offered while `wb_full` is high and `mem_ack` is low is discarded. It is never forwarded to a load and never written to the cache.
- R6: A store offered while `wb_full` is high and `mem_ack` is high is accepted at the same edge that removes the oldest entry, and `wb_full` stays high.
- R7: A lookup with `ld_valid` high whose `ld_addr` matches a held entry gives `fwd_hit` high one cycle later. `fwd_data` then carries the data of the youngest matching entry.
- R8: A lookup that matches no held entry, or a cycle with `ld_valid` low, gives `fwd_hit` low and `fwd_data` zero one cycle later.
- R9: A lookup sees the contents as they stood before its own clock edge. A store accepted in the same cycle is not seen. An entry being acknowledged in the same cycle is still seen.
- R10: After a synchronous active-low reset the queue is empty: `mem_req`, `wb_full` and `fwd_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Commit offers a store this cycle |
| st_addr | input | AW (32) | Store word address |
| st_data | input | DW (32) | Store data |
| wb_full | output | 1 | All slots occupied; commit should stall unless mem_ack is high |
| mem_req | output | 1 | Cache write request for the oldest entry |
| mem_addr | output | AW (32) | Address of the oldest entry |
| mem_data | output | DW (32) | Data of the oldest entry |
| mem_ack | input | 1 | Cache has completed the requested write |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_addr | input | AW (32) | Load word address |
| fwd_hit | output | 1 | Lookup of the previous cycle matched a held entry |
| fwd_data | output | DW (32) | Forwarded data, zero on a miss |

## Verification
A lookup result is due one clock edge after its `ld_valid` cycle. This holds for a hit and a miss alike. `wb_full`, `mem_req` and the presented head entry change in the cycle after the edge that enqueues or acknowledges. The bench drives every input at the falling edge and checks all outputs at the next falling edge. It compares them with an ordered model of held stores, which is updated once for the single rising edge in between. The expected lookup result is taken from the model before that update, so the same-cycle cases of R9 fall out of the timing rather than needing special handling.

// File: rtl/swb_pkg.sv
// Shared widths and entry type for the committed-store drain queue.
// Assumes word-aligned, full-word accesses only.
package swb_pkg;
    parameter int SWB_AW = 32;
    parameter int SWB_DW = 32;

    typedef struct packed {
        logic [SWB_AW-1:0] addr;
        logic [SWB_DW-1:0] data;
    } swb_entry_t;
endpackage

// File: rtl/swb_queue.sv
// Circular storage of committed stores with head/tail pointers and an
// occupancy count. Assumes the parent gates push against overflow (push
// while full only together with pop) and pop against empty.
module swb_queue
    import swb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  swb_entry_t       push_ent_i,
    input  logic             pop_i,
    output swb_entry_t       ents_o [DEPTH],
    output logic [PW-1:0]    head_o,
    output logic [CW-1:0]    count_o
);
    logic [PW-1:0] tail_q;
    swb_entry_t    ents_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and count on enqueue/dequeue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_o  <= '0;
            tail_q  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) tail_q <= wrap_inc(tail_q);
            if (pop_i)  head_o <= wrap_inc(head_o);
            if (push_i && !pop_i)      count_o <= count_o + 1'b1;
            else if (pop_i && !push_i) count_o <= count_o - 1'b1;
        end
    end

    // Write the accepted store into the tail slot.
    always_ff @(posedge clk) begin
        if (push_i) ents_q[tail_q] <= push_ent_i;
    end

    assign ents_o = ents_q;

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> count_o != '0);
    a_r5_full_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CW'(DEPTH) && !pop_i) |=> $stable(tail_q));
endmodule

// File: rtl/swb_lookup.sv
// Searches held entries for a load address and registers the result, so
// hit and miss both arrive exactly one cycle after the lookup. Scans from
// oldest to youngest so the youngest match wins. Assumes entries at
// positions head..head+count-1 (modulo DEPTH) are the valid ones.
module swb_lookup
    import swb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  swb_entry_t        ents_i [DEPTH],
    input  logic [PW-1:0]     head_i,
    input  logic [CW-1:0]     count_i,
    input  logic              ld_valid_i,
    input  logic [SWB_AW-1:0] ld_addr_i,
    output logic              fwd_hit_o,
    output logic [SWB_DW-1:0] fwd_data_o
);
    logic              hit_c;
    logic [SWB_DW-1:0] data_c;

    // Age-ordered match; a younger match overrides an older one.
    always_comb begin
        hit_c  = 1'b0;
        data_c = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] sel;
            sel = PW'((int'(head_i) + k) % DEPTH);
            if (k < int'(count_i) && ents_i[sel].addr == ld_addr_i) begin
                hit_c  = 1'b1;
                data_c = ents_i[sel].data;
            end
        end
    end

    // Register the result for fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_hit_o  <= 1'b0;
            fwd_data_o <= '0;
        end else begin
            fwd_hit_o  <= ld_valid_i && hit_c;
            fwd_data_o <= (ld_valid_i && hit_c) ? data_c : '0;
        end
    end

    a_r7_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit_o |-> $past(count_i) != '0);
    a_r8_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> !fwd_hit_o);
endmodule

// File: rtl/store_wb_buffer.sv
// Committed-store drain queue with load forwarding. Accepts one store per
// cycle from commit, drains the oldest to the cache via req/ack, and
// answers load lookups one cycle later with the youngest matching data.
// Assumes mem_ack is only raised while mem_req is high.
module store_wb_buffer
    import swb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = SWB_AW,
    localparam int DW = SWB_DW,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          wb_full,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ack,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          fwd_hit,
    output logic [DW-1:0] fwd_data
);
    swb_entry_t    ents [DEPTH];
    swb_entry_t    new_ent;
    logic [PW-1:0] head;
    logic [CW-1:0] count;
    logic          do_pop;
    logic          do_push;

    // Derive handshake decisions from occupancy and the cache acknowledge.
    always_comb begin
        wb_full  = (count == CW'(DEPTH));
        mem_req  = (count != '0);
        do_pop   = mem_ack && mem_req;
        do_push  = st_valid && (!wb_full || do_pop);
        new_ent  = '{addr: st_addr, data: st_data};
        mem_addr = ents[head].addr;
        mem_data = ents[head].data;
    end

    swb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (do_push),
        .push_ent_i (new_ent),
        .pop_i      (do_pop),
        .ents_o     (ents),
        .head_o     (head),
        .count_o    (count)
    );

    swb_lookup #(.DEPTH(DEPTH)) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .ents_i     (ents),
        .head_i     (head),
        .count_i    (count),
        .ld_valid_i (ld_valid),
        .ld_addr_i  (ld_addr),
        .fwd_hit_o  (fwd_hit),
        .fwd_data_o (fwd_data)
    );

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_full && !mem_ack) |=> wb_full);
    a_r6_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_full && mem_ack && st_valid) |=> wb_full);
    a_r4_full_leave: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_full) |-> $past(mem_ack));
endmodule

// File: tb/sim_store_wb_buffer.sv
`timescale 1ns/1ps
// Bench for store_wb_buffer: directed corners plus seeded random traffic,
// checked against an ordered model of held stores.
module sim_store_wb_buffer;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0;
    logic        wb_full, mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_data;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        fwd_hit;
    logic [31:0] fwd_data;

    int checks = 0, errors = 0;
    logic [31:0] mq_a [$];
    logic [31:0] mq_d [$];
    logic        fwd_pend = 1'b0;
    logic        exp_hit;
    logic [31:0] exp_data;
    string       fwd_tag = "R7";

    always #2 clk = ~clk;

    store_wb_buffer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .wb_full(wb_full), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .fwd_hit(fwd_hit),
        .fwd_data(fwd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the model; call at a falling edge.
    task automatic check_outputs();
        if (fwd_pend) begin
            chk(fwd_hit == exp_hit, {fwd_tag, " hit"}, 32'(fwd_hit), 32'(exp_hit));
            chk(fwd_data == exp_data, {fwd_tag, " data"}, fwd_data, exp_data);
        end
        chk(wb_full == (mq_a.size() == DEPTH), "R4 full", 32'(wb_full),
            32'(mq_a.size() == DEPTH));
        chk(mem_req == (mq_a.size() != 0), "R2 req", 32'(mem_req),
            32'(mq_a.size() != 0));
        if (mq_a.size() != 0) begin
            chk(mem_addr == mq_a[0], "R3 head addr", mem_addr, mq_a[0]);
            chk(mem_data == mq_d[0], "R1 head data order", mem_data, mq_d[0]);
        end
    endtask

    // One cycle: check, drive inputs, predict the coming edge.
    task automatic step(input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                        input bit lv, input logic [31:0] la, input bit ack_ok,
                        input string tag);
        bit pop, acc;
        @(negedge clk);
        check_outputs();
        st_valid = sv; st_addr = sa; st_data = sd;
        ld_valid = lv; ld_addr = la;
        mem_ack  = ack_ok && (mq_a.size() != 0);
        exp_hit = 1'b0; exp_data = '0;
        if (lv) begin
            for (int i = 0; i < mq_a.size(); i++)
                if (mq_a[i] == la) begin exp_hit = 1'b1; exp_data = mq_d[i]; end
        end
        fwd_pend = 1'b1;
        fwd_tag  = (tag != "") ? tag : (exp_hit ? "R7" : "R8");
        pop = mem_ack;
        acc = sv && (mq_a.size() < DEPTH || pop);
        if (pop) begin void'(mq_a.pop_front()); void'(mq_d.pop_front()); end
        if (acc) begin mq_a.push_back(sa); mq_d.push_back(sd); end
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!mem_req && !wb_full && !fwd_hit, "R10 reset",
            {29'd0, mem_req, wb_full, fwd_hit}, 32'd0);

        // R9: store and lookup of the same address in one cycle: miss
        step(1'b1, 32'h40, 32'hA0, 1'b1, 32'h40, 1'b0, "R9 same-cycle store");
        step(1'b0, 0, 0, 1'b1, 32'h40, 1'b0, "R7 single");
        // R9: lookup while that entry is being acknowledged still hits
        step(1'b0, 0, 0, 1'b1, 32'h40, 1'b1, "R9 draining entry");
        idle("R8 after drain");

        // R7: fill with several same-address stores, no acknowledges
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, (i % 2 == 0) ? 32'h80 : 32'h84, 32'h100 + i, 1'b0, 0, 1'b0, "");
        step(1'b0, 0, 0, 1'b1, 32'h80, 1'b0, "");
        step(1'b0, 0, 0, 1'b1, 32'h84, 1'b0, "R7 youngest match");
        // R5: store while full without ack is dropped
        step(1'b1, 32'hC0, 32'hDEAD, 1'b0, 0, 1'b0, "R8 pre-drop");
        step(1'b0, 0, 0, 1'b1, 32'hC0, 1'b0, "R5 dropped store");
        idle("R5 after lookup");
        // R6: store while full with ack is taken, full stays
        step(1'b1, 32'hC4, 32'hBEEF, 1'b0, 0, 1'b1, "R6 swap");
        step(1'b0, 0, 0, 1'b1, 32'hC4, 1'b0, "R6 swapped store visible");
        @(negedge clk);
        chk(wb_full, "R6 full held", 32'(wb_full), 32'd1);
        // R4: ack without store frees a slot next cycle
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, "R4 ack");
        // drain the rest with variable latency
        lat = 0;
        while (mq_a.size() != 0) begin
            step(1'b0, 0, 0, 1'b1, 32'hC0, lat == 0, "R5 never drained");
            lat = (lat == 0) ? int'($urandom % 4) : lat - 1;
        end
        idle("");

        // random traffic over a small address set
        lat = int'($urandom % 4);
        for (int c = 0; c < 4000; c++) begin
            bit ak;
            ak = (lat == 0) && mem_req;
            step(($urandom % 3) != 0, 32'(($urandom % 4) * 4), $urandom,
                 ($urandom % 2) == 1, 32'(($urandom % 5) * 4), ak, "");
            if (ak) lat = int'($urandom % 4);
            else if (lat > 0 && mq_a.size() != 0) lat--;
        end
        idle("");
        @(negedge clk);
        check_outputs();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule